// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block walks an external programmable-logic fabric through its configuration life cycle with no software stepping. A host raises a one-cycle start pulse. The block then latches a 4-bit mode-select strap and decodes it into a configuration data width and a clock-to-data ratio, which downstream data-path logic uses. It takes control of the configuration lines, holds the fabric in reset, and then walks it through the configure, initialise and user phases. At each step it checks a fabric status code before moving on.

Between phases it emits bounded bursts of configuration clocks. Every wait is limited by a cycle timeout, and each failing wait leaves its own error code for the host. A separate filter reports that the fabric is ready only when the init-done line has been high on two consecutive samples and the status shows user mode.

Top module: `cfg_seq_top`

## Requirements
- R1: Throughout reset and just after it, the outputs are: `busy_o`, `done_o`, `err_o`, `drive_en_o`, `cfg_pull_o`, `bus_cfg_en_o`, `dclk_o` and `ready_o` low; `ce_n_o` high; `irq_clr_o` and `err_code_o` zero; `wide_o` 0; and `ratio_o` 1.
- R2: `wide_o` is 1 (32-bit data) when the latched strap bit 3 is set and 0 (16-bit data) when it is clear.
- R3: `ratio_o` is the ratio written as a number. Strap bits [1:0] = 0, 1, 2 give 1, 4, 8 when wide and 1, 2, 4 when narrow. A value of 3 gives 1, and strap bit 2 has no effect.
- R4: The strap is captured on the clock edge that accepts start. `wide_o` and `ratio_o` then stay unchanged while `busy_o` is high. A start pulse seen while busy is ignored.
- R5: After start, `ce_n_o` goes low and `drive_en_o` goes high first. In the next cycle `cfg_pull_o` goes high and stays high until the status input reads reset phase (code 1). It then drops, and the block waits for configuration phase (code 2). Status codes: 1 reset, 2 configure, 3 init, 4 user.
- R6: On configuration phase, `irq_clr_o` carries 12'hFFF for exactly one cycle. `bus_cfg_en_o` rises in the following cycle, and the block waits for `load_done_i` with no time limit.
- R7: After `load_done_i`, exactly INIT_CLKS (default 4) `dclk_o` high cycles are issued. The block then waits for status init (3) or user (4).
- R8: Next, exactly USER_CLKS (default 0x5000) `dclk_o` high cycles are issued and the block waits for user mode. On success `drive_en_o` falls and `done_o` rises together with `busy_o` falling. `ce_n_o` stays low and `done_o` holds until the next start.
- R9: A wait that runs TIMEOUT cycles without success aborts with `err_code_o`: 1 for the reset wait, 2 for the configure wait, 3 for a clock burst that does not finish, 4 for the init wait and 5 for the user wait.
- R10: A reset-phase wait that never succeeds keeps `cfg_pull_o` high for exactly TIMEOUT cycles before the abort.
- R11: On an abort, `ce_n_o` returns high and `drive_en_o`, `cfg_pull_o`, `bus_cfg_en_o` and `dclk_o` go low. `err_o` and `err_code_o` hold until the next start.
- R12: `ready_o` is high in a cycle only if `init_done_i` was high at the last two clock edges and status read user (4) at the last one. A one-cycle high on `init_done_i` never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request from the host |
| load_done_i | input | 1 | Bitstream load finished |
| strap_i | input | 4 | Mode-select strap |
| fab_mode_i | input | 3 | Fabric status code |
| init_done_i | input | 1 | Fabric init-done line |
| ce_n_o | output | 1 | Active-low chip enable to the fabric |
| drive_en_o | output | 1 | Block owns the configuration lines |
| cfg_pull_o | output | 1 | Holds the fabric in reset phase |
| bus_cfg_en_o | output | 1 | Configuration data bus enable |
| irq_clr_o | output | 12 | Monitor interrupt clear strobe |
| dclk_o | output | 1 | Configuration clock enable, one per cycle |
| wide_o | output | 1 | Decoded 32-bit data width |
| ratio_o | output | 4 | Decoded clock-to-data ratio |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished in user mode |
| err_o | output | 1 | Sequence aborted |
| err_code_o | output | 3 | Abort cause |
| ready_o | output | 1 | Filtered fabric ready |

## Verification
The assertions assume that `fab_mode_i`, `init_done_i`, `load_done_i` and `start_i` are synchronous to `clk`, and that reset is held long enough to clear the registered status history. They also assume that both burst lengths are at least one. The stimulus changes every input only at falling edges. It lets each status code stand for several cycles, and it runs a second instance whose timeout is shorter than its user burst, so the burst abort is reached without breaking these assumptions.

// File: rtl/cfg_seq_pkg.sv
// Shared codes for the fabric configuration sequencer.
// Assumes a 3-bit fabric status code and a 12-bit monitor interrupt vector.
package cfg_seq_pkg;

    localparam int MODE_W = 3;
    localparam int IRQ_W  = 12;

    // Fabric status codes watched by the sequencer
    localparam logic [MODE_W-1:0] FM_RESET = 3'd1;
    localparam logic [MODE_W-1:0] FM_CFG   = 3'd2;
    localparam logic [MODE_W-1:0] FM_INIT  = 3'd3;
    localparam logic [MODE_W-1:0] FM_USER  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_PULL,
        S_WAIT_CFG,
        S_CLR,
        S_LOAD,
        S_BURST_A,
        S_WAIT_INIT,
        S_BURST_B,
        S_WAIT_USER
    } seq_state_e;

    typedef enum logic [2:0] {
        E_NONE  = 3'd0,
        E_RESET = 3'd1,
        E_CFG   = 3'd2,
        E_BURST = 3'd3,
        E_INIT  = 3'd4,
        E_USER  = 3'd5
    } seq_err_e;

endpackage

// File: rtl/cfg_strap_decode.sv
// Strap decoder: turns the latched mode-select strap into data width and
// clock-to-data ratio. Purely combinational. Assumes the caller holds the
// strap stable while the result is in use. Bit 2 is reserved and ignored.
module cfg_strap_decode (
    input  logic [3:0] strap_i,
    output logic       wide_o,
    output logic [3:0] ratio_o
);

    // Decode width and ratio from the strap pattern
    always_comb begin
        casez (strap_i)
            4'b1?01: begin wide_o = 1'b1; ratio_o = 4'd4; end
            4'b1?10: begin wide_o = 1'b1; ratio_o = 4'd8; end
            4'b1?00,
            4'b1?11: begin wide_o = 1'b1; ratio_o = 4'd1; end
            4'b0?01: begin wide_o = 1'b0; ratio_o = 4'd2; end
            4'b0?10: begin wide_o = 1'b0; ratio_o = 4'd4; end
            default: begin wide_o = 1'b0; ratio_o = 4'd1; end
        endcase
    end

endmodule

// File: rtl/cfg_wait_timer.sv
// Wait timer: counts cycles spent in one waiting phase and flags the last
// permitted cycle. clr_i restarts the count on every phase change.
// Assumes LIMIT >= 1; a phase may last at most LIMIT cycles.
module cfg_wait_timer #(
    parameter int LIMIT = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    // Count cycles in the current wait, restart on phase change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_clk_burst.sv
// Clock burst generator: after load_i emits count_i consecutive dclk_o
// cycles, then pulses done_o in the cycle after the last one.
// Assumes count_i >= 1; abort_i drops any burst in flight.
module cfg_clk_burst #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             abort_i,
    output logic             dclk_o,
    output logic             done_o
);

    logic [CNT_W-1:0] rem_q;
    logic             done_q;

    assign dclk_o = (rem_q != '0);
    assign done_o = done_q;

    // Track remaining clocks of the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (abort_i) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= count_i;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Raise completion one cycle after the final clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (rem_q == CNT_W'(1)) && !abort_i && !load_i;
        end
    end

endmodule

// File: rtl/cfg_ready_filter.sv
// Ready filter: reports the fabric ready only after init-done was high on
// two consecutive edges while the status reads user mode.
// Assumes init_done_i is already synchronous to clk.
module cfg_ready_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic init_done_i,
    input  logic user_mode_i,
    output logic ready_o
);

    logic id_q;
    logic rdy_q;

    assign ready_o = rdy_q;

    // Keep the previous init-done sample
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= 1'b0;
        else        id_q <= init_done_i;
    end

    // Combine two samples with the user-mode status
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= init_done_i && id_q && user_mode_i;
    end

endmodule

// File: rtl/cfg_seq_top.sv
// Fabric configuration sequencer. On start it latches the strap, takes the
// configuration lines, and steps the fabric through reset, configure,
// init and user phases with a bounded wait and a clock burst between them.
// Assumes all inputs are synchronous to clk and both burst lengths are >= 1.
module cfg_seq_top #(
    parameter int TIMEOUT   = 1_000_000,
    parameter int INIT_CLKS = 4,
    parameter int USER_CLKS = 32'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        load_done_i,
    input  logic [3:0]  strap_i,
    input  logic [2:0]  fab_mode_i,
    input  logic        init_done_i,
    output logic        ce_n_o,
    output logic        drive_en_o,
    output logic        cfg_pull_o,
    output logic        bus_cfg_en_o,
    output logic [11:0] irq_clr_o,
    output logic        dclk_o,
    output logic        wide_o,
    output logic [3:0]  ratio_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [2:0]  err_code_o,
    output logic        ready_o
);
    import cfg_seq_pkg::*;

    localparam int BURST_MAX = (INIT_CLKS > USER_CLKS) ? INIT_CLKS : USER_CLKS;
    localparam int BURST_W   = $clog2(BURST_MAX + 1);

    seq_state_e       state_q, state_d;
    seq_err_e         fail_code;
    logic             fail;
    logic             success;
    logic             accept;
    logic [3:0]       strap_q;
    logic             ce_n_q, drv_q, bus_q, done_q, err_q;
    logic [2:0]       code_q;
    logic             tmr_clr, tmr_run, tmr_exp;
    logic             burst_load, burst_done;
    logic [BURST_W-1:0] burst_cnt;

    cfg_strap_decode u_dec (
        .strap_i (strap_q),
        .wide_o  (wide_o),
        .ratio_o (ratio_o)
    );

    cfg_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    cfg_clk_burst #(.CNT_W(BURST_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (burst_load),
        .count_i (burst_cnt),
        .abort_i (fail),
        .dclk_o  (dclk_o),
        .done_o  (burst_done)
    );

    cfg_ready_filter u_rdy (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done_i (init_done_i),
        .user_mode_i (fab_mode_i == FM_USER),
        .ready_o     (ready_o)
    );

    // Next-state, burst launch and abort decision
    always_comb begin
        state_d    = state_q;
        fail       = 1'b0;
        fail_code  = E_NONE;
        burst_load = 1'b0;
        burst_cnt  = '0;
        case (state_q)
            S_IDLE:      if (start_i) state_d = S_ARM;
            S_ARM:       state_d = S_PULL;
            S_PULL: begin
                if (fab_mode_i == FM_RESET) state_d = S_WAIT_CFG;
                else if (tmr_exp) begin fail = 1'b1; fail_code = E_RESET; end
            end
            S_WAIT_CFG: begin
                if (fab_mode_i == FM_CFG) state_d = S_CLR;
                else if (tmr_exp) begin fail = 1'b1; fail_code = E_CFG; end
            end
            S_CLR:       state_d = S_LOAD;
            S_LOAD: begin
                if (load_done_i) begin
                    state_d    = S_BURST_A;
                    burst_load = 1'b1;
                    burst_cnt  = BURST_W'(INIT_CLKS);
                end
            end
            S_BURST_A: begin
                if (burst_done) state_d = S_WAIT_INIT;
                else if (tmr_exp) begin fail = 1'b1; fail_code = E_BURST; end
            end
            S_WAIT_INIT: begin
                if (fab_mode_i == FM_INIT || fab_mode_i == FM_USER) begin
                    state_d    = S_BURST_B;
                    burst_load = 1'b1;
                    burst_cnt  = BURST_W'(USER_CLKS);
                end else if (tmr_exp) begin
                    fail = 1'b1; fail_code = E_INIT;
                end
            end
            S_BURST_B: begin
                if (burst_done) state_d = S_WAIT_USER;
                else if (tmr_exp) begin fail = 1'b1; fail_code = E_BURST; end
            end
            S_WAIT_USER: begin
                if (fab_mode_i == FM_USER) state_d = S_IDLE;
                else if (tmr_exp) begin fail = 1'b1; fail_code = E_USER; end
            end
            default:     state_d = S_IDLE;
        endcase
        if (fail) state_d = S_IDLE;
    end

    assign accept  = (state_q == S_IDLE) && start_i;
    assign success = (state_q == S_WAIT_USER) && (fab_mode_i == FM_USER);
    assign tmr_clr = (state_d != state_q);
    assign tmr_run = (state_q == S_PULL)      || (state_q == S_WAIT_CFG)  ||
                     (state_q == S_BURST_A)   || (state_q == S_WAIT_INIT) ||
                     (state_q == S_BURST_B)   || (state_q == S_WAIT_USER);

    // Advance the sequence state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Capture the strap only when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)      strap_q <= 4'd0;
        else if (accept) strap_q <= strap_i;
    end

    // Drive ownership of the configuration lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            drv_q  <= 1'b0;
        end else if (accept) begin
            ce_n_q <= 1'b0;
            drv_q  <= 1'b1;
        end else if (fail) begin
            ce_n_q <= 1'b1;
            drv_q  <= 1'b0;
        end else if (success) begin
            drv_q  <= 1'b0;
        end
    end

    // Configuration bus enable, set after the interrupt clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_q <= 1'b0;
        else if (accept || fail)    bus_q <= 1'b0;
        else if (state_q == S_CLR)  bus_q <= 1'b1;
    end

    // Host handshake result, held until the next start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            code_q <= E_NONE;
        end else if (accept) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            code_q <= E_NONE;
        end else if (fail) begin
            err_q  <= 1'b1;
            code_q <= fail_code;
        end else if (success) begin
            done_q <= 1'b1;
        end
    end

    assign ce_n_o       = ce_n_q;
    assign drive_en_o   = drv_q;
    assign bus_cfg_en_o = bus_q;
    assign cfg_pull_o   = (state_q == S_PULL);
    assign irq_clr_o    = (state_q == S_CLR) ? {IRQ_W{1'b1}} : {IRQ_W{1'b0}};
    assign busy_o       = (state_q != S_IDLE);
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign err_code_o   = code_q;

endmodule

// File: rtl/cfg_seq_chk.sv
// Assertion checker for the sequencer, bound to every cfg_seq_top instance.
// Assumes inputs synchronous to clk and reset held for at least two cycles.
module cfg_seq_chk #(
    parameter int TIMEOUT = 1_000_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  fab_mode_i,
    input logic        init_done_i,
    input logic        ce_n_o,
    input logic        drive_en_o,
    input logic        cfg_pull_o,
    input logic        bus_cfg_en_o,
    input logic [11:0] irq_clr_o,
    input logic        dclk_o,
    input logic        wide_o,
    input logic [3:0]  ratio_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [2:0]  err_code_o
);

    int unsigned pull_run;

    // Length of the current stretch with cfg_pull_o high
    always_ff @(posedge clk) begin
        if (!rst_n)          pull_run <= 0;
        else if (cfg_pull_o) pull_run <= pull_run + 1;
        else                 pull_run <= 0;
    end

    a_r3_ratio_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ratio_o) == 1);

    a_r3_narrow_no_x8: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_o |-> ratio_o != 4'd8);

    a_r4_strap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> ($stable(wide_o) && $stable(ratio_o)));

    a_r5_pull_owned: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pull_o |-> (drive_en_o && !ce_n_o && busy_o));

    a_r6_irq_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_o != 12'd0) |-> (irq_clr_o == 12'hFFF));

    a_r6_irq_then_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_o != 12'd0) |=> (irq_clr_o == 12'd0 && bus_cfg_en_o));

    a_r7_dclk_owned: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> (drive_en_o && bus_cfg_en_o && busy_o));

    a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!drive_en_o && !err_o));

    a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != 3'd0 && err_code_o <= 3'd5));

    a_r10_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pull_o |-> (pull_run < TIMEOUT));

    a_r11_err_released: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ce_n_o && !drive_en_o && !cfg_pull_o && !bus_cfg_en_o && !dclk_o));

endmodule

bind cfg_seq_top cfg_seq_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fab_mode_i   (fab_mode_i),
    .init_done_i  (init_done_i),
    .ce_n_o       (ce_n_o),
    .drive_en_o   (drive_en_o),
    .cfg_pull_o   (cfg_pull_o),
    .bus_cfg_en_o (bus_cfg_en_o),
    .irq_clr_o    (irq_clr_o),
    .dclk_o       (dclk_o),
    .wide_o       (wide_o),
    .ratio_o      (ratio_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/cfg_seq_top_tb_top.sv
`timescale 1ns/1ps
module cfg_seq_top_tb_top;

    localparam int TMO   = 300;
    localparam int ICLK  = 4;
    localparam int UCLK  = 64;
    localparam int B_TMO = 16;
    localparam int B_UCL = 40;

    // {strap, wide, ratio}
    localparam logic [8:0] STRAP_TBL [0:15] = '{
        {4'h0, 1'b0, 4'd1}, {4'h1, 1'b0, 4'd2}, {4'h2, 1'b0, 4'd4}, {4'h3, 1'b0, 4'd1},
        {4'h4, 1'b0, 4'd1}, {4'h5, 1'b0, 4'd2}, {4'h6, 1'b0, 4'd4}, {4'h7, 1'b0, 4'd1},
        {4'h8, 1'b1, 4'd1}, {4'h9, 1'b1, 4'd4}, {4'hA, 1'b1, 4'd8}, {4'hB, 1'b1, 4'd1},
        {4'hC, 1'b1, 4'd1}, {4'hD, 1'b1, 4'd4}, {4'hE, 1'b1, 4'd8}, {4'hF, 1'b1, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        load_done_i = 1'b0;
    logic [3:0]  strap_i = 4'd0;
    logic [2:0]  fab_mode_i = 3'd0;
    logic        init_done_i = 1'b0;

    logic        ce_n_o, drive_en_o, cfg_pull_o, bus_cfg_en_o, dclk_o;
    logic [11:0] irq_clr_o;
    logic        wide_o, busy_o, done_o, err_o, ready_o;
    logic [3:0]  ratio_o;
    logic [2:0]  err_code_o;

    logic        b_ce_n, b_drv, b_pull, b_bus, b_dclk, b_wide, b_busy, b_done, b_err, b_rdy;
    logic [11:0] b_irq;
    logic [3:0]  b_ratio;
    logic [2:0]  b_code;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    cfg_seq_top #(.TIMEOUT(TMO), .INIT_CLKS(ICLK), .USER_CLKS(UCLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_done_i(load_done_i),
        .strap_i(strap_i), .fab_mode_i(fab_mode_i), .init_done_i(init_done_i),
        .ce_n_o(ce_n_o), .drive_en_o(drive_en_o), .cfg_pull_o(cfg_pull_o),
        .bus_cfg_en_o(bus_cfg_en_o), .irq_clr_o(irq_clr_o), .dclk_o(dclk_o),
        .wide_o(wide_o), .ratio_o(ratio_o), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .err_code_o(err_code_o), .ready_o(ready_o)
    );

    cfg_seq_top #(.TIMEOUT(B_TMO), .INIT_CLKS(ICLK), .USER_CLKS(B_UCL)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_done_i(load_done_i),
        .strap_i(strap_i), .fab_mode_i(fab_mode_i), .init_done_i(init_done_i),
        .ce_n_o(b_ce_n), .drive_en_o(b_drv), .cfg_pull_o(b_pull),
        .bus_cfg_en_o(b_bus), .irq_clr_o(b_irq), .dclk_o(b_dclk),
        .wide_o(b_wide), .ratio_o(b_ratio), .busy_o(b_busy), .done_o(b_done),
        .err_o(b_err), .err_code_o(b_code), .ready_o(b_rdy)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [3:0] s);
        strap_i = s;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 2000 && busy_o; g++) tick();
    endtask

    // Start and drive the fabric status up to the load phase
    task automatic run_to_load(input logic [3:0] s);
        fab_mode_i = 3'd0;
        pulse_start(s);
        check_eq("R5 ce_n low after start", ce_n_o, 0);
        check_eq("R5 drive_en high after start", drive_en_o, 1);
        check_eq("R5 pull not yet", cfg_pull_o, 0);
        tick();
        check_eq("R5 pull asserted", cfg_pull_o, 1);
        tick();
        check_eq("R5 pull held before reset phase", cfg_pull_o, 1);
        fab_mode_i = 3'd1;
        tick();
        check_eq("R5 pull released", cfg_pull_o, 0);
        check_eq("R5 still busy", busy_o, 1);
        fab_mode_i = 3'd2;
        tick();
        check_eq("R6 irq clear all bits", irq_clr_o, 12'hFFF);
        check_eq("R6 bus not yet", bus_cfg_en_o, 0);
        tick();
        check_eq("R6 irq clear one cycle", irq_clr_o, 0);
        check_eq("R6 bus enabled", bus_cfg_en_o, 1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        repeat (5) tick();
        // R1 reset state (still in reset)
        check_eq("R1 busy in reset", busy_o, 0);
        check_eq("R1 ce_n in reset", ce_n_o, 1);
        rst_n = 1'b1;
        tick();
        check_eq("R1 busy", busy_o, 0);
        check_eq("R1 done", done_o, 0);
        check_eq("R1 err", err_o, 0);
        check_eq("R1 code", err_code_o, 0);
        check_eq("R1 ce_n", ce_n_o, 1);
        check_eq("R1 drive_en", drive_en_o, 0);
        check_eq("R1 pull", cfg_pull_o, 0);
        check_eq("R1 bus", bus_cfg_en_o, 0);
        check_eq("R1 dclk", dclk_o, 0);
        check_eq("R1 irq", irq_clr_o, 0);
        check_eq("R1 ready", ready_o, 0);
        check_eq("R1 wide", wide_o, 0);
        check_eq("R1 ratio", ratio_o, 1);

        // Strap table: decode, hold, and reset-phase timeout
        for (int k = 0; k < 16; k++) begin
            pulse_start(STRAP_TBL[k][8:5]);
            check_eq("R2 width", wide_o, STRAP_TBL[k][4]);
            check_eq("R3 ratio", ratio_o, STRAP_TBL[k][3:0]);
            strap_i = ~STRAP_TBL[k][8:5];
            tick();
            check_eq("R4 width held", wide_o, STRAP_TBL[k][4]);
            check_eq("R4 ratio held", ratio_o, STRAP_TBL[k][3:0]);
            n = 0;
            for (int g = 0; g < 2000 && busy_o; g++) begin
                if (cfg_pull_o) n++;
                tick();
            end
            check_eq("R10 pull window", n, TMO - 1 + 1);
            check_eq("R9 reset-wait code", err_code_o, 1);
            check_eq("R11 err held", err_o, 1);
            check_eq("R11 ce_n released", ce_n_o, 1);
            check_eq("R11 drive released", drive_en_o, 0);
        end
        repeat (3) tick();
        check_eq("R11 err still held", err_o, 1);

        // Full run through init phase
        run_to_load(4'h9);
        strap_i = 4'h2;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check_eq("R4 start ignored width", wide_o, 1);
        check_eq("R4 start ignored ratio", ratio_o, 4);
        check_eq("R4 start ignored pull", cfg_pull_o, 0);
        check_eq("R4 start ignored irq", irq_clr_o, 0);
        repeat (5) tick();
        check_eq("R6 waits for load", busy_o, 1);
        check_eq("R6 no clocks before load", dclk_o, 0);
        load_done_i = 1'b1;
        tick();
        load_done_i = 1'b0;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (dclk_o) n++;
            tick();
        end
        check_eq("R7 init clocks", n, ICLK);
        fab_mode_i = 3'd3;
        tick();
        n = 0;
        for (int i = 0; i < UCLK + 6; i++) begin
            if (dclk_o) n++;
            tick();
        end
        check_eq("R8 user clocks", n, UCLK);
        check_eq("R8 waiting for user", busy_o, 1);
        check_eq("R9 burst abort code", b_code, 3);
        check_eq("R11 burst abort drive", b_drv, 0);
        check_eq("R11 burst abort ce_n", b_ce_n, 1);
        fab_mode_i = 3'd4;
        tick();
        check_eq("R8 done", done_o, 1);
        check_eq("R8 idle", busy_o, 0);
        check_eq("R8 drive released", drive_en_o, 0);
        check_eq("R8 ce_n kept", ce_n_o, 0);
        check_eq("R8 no error", err_o, 0);

        // Run with user mode reported directly in the init wait
        run_to_load(4'h5);
        check_eq("R3 narrow ratio", ratio_o, 2);
        load_done_i = 1'b1;
        tick();
        load_done_i = 1'b0;
        repeat (6) tick();
        fab_mode_i = 3'd4;
        tick();
        n = 0;
        for (int i = 0; i < UCLK + 6; i++) begin
            if (dclk_o) n++;
            tick();
        end
        check_eq("R8 user clocks direct", n, UCLK);
        check_eq("R8 done direct", done_o, 1);

        // Configure-wait timeout
        fab_mode_i = 3'd0;
        pulse_start(4'h0);
        fab_mode_i = 3'd1;
        wait_idle();
        check_eq("R9 cfg-wait code", err_code_o, 2);
        check_eq("R8 done cleared by start", done_o, 0);

        // Init-wait timeout
        run_to_load(4'h0);
        load_done_i = 1'b1;
        tick();
        load_done_i = 1'b0;
        wait_idle();
        check_eq("R9 init-wait code", err_code_o, 4);
        check_eq("R11 bus released", bus_cfg_en_o, 0);

        // User-wait timeout
        run_to_load(4'h0);
        load_done_i = 1'b1;
        tick();
        load_done_i = 1'b0;
        repeat (6) tick();
        fab_mode_i = 3'd3;
        wait_idle();
        check_eq("R9 user-wait code", err_code_o, 5);

        // Ready filter
        fab_mode_i = 3'd4;
        init_done_i = 1'b0;
        repeat (2) tick();
        check_eq("R12 ready low", ready_o, 0);
        init_done_i = 1'b1;
        tick();
        init_done_i = 1'b0;
        check_eq("R12 glitch first", ready_o, 0);
        tick();
        check_eq("R12 glitch rejected", ready_o, 0);
        tick();
        init_done_i = 1'b1;
        tick();
        check_eq("R12 one sample", ready_o, 0);
        tick();
        check_eq("R12 two samples", ready_o, 1);
        fab_mode_i = 3'd3;
        tick();
        check_eq("R12 needs user mode", ready_o, 0);

        finish_run();
    end

endmodule